// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block keeps the status and interrupt side of an SPI controller's two byte FIFOs: one that software fills for transmission and one that the shift engine fills with received bytes. It models only how full each FIFO is (0 to 64 bytes), not the bytes themselves. It keeps a programmable trigger level per FIFO, lets software flush either FIFO, reports both byte counts, and gathers a set of sticky status flags. Those flags are ORed through a per-bit enable mask onto one interrupt line.

Software reaches the unit through a small word-addressed register port. Address 0 is control, 1 is the byte counts, 2 is the interrupt enable, 3 is the interrupt status, 4 is the transmit data window and 5 is the receive data window. A write to address 4 adds one byte to the transmit FIFO. A read from address 5 takes one byte from the receive FIFO. On the engine side, one-cycle pulses remove a transmit byte, add a receive byte, mark the end of a transfer, or mark chip select going inactive.

Status flags are cleared by writing 1 to them. Flags that describe a level (threshold, empty, full) come back one cycle after being cleared if their condition still holds. Flags that record an event stay set until software clears them.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset, the control register reads 0x0030_0010 (transmit trigger 48 in bits 23:16, receive trigger 16 in bits 7:0, both flush bits 0), the enable and status registers read 0, both counts are 0, and irq is low.
- R2: A write to control (address 0) loads the transmit trigger from bits 23:16 and the receive trigger from bits 7:0, and both read back unchanged.
- R3: Writing 1 to control bit 31 flushes the transmit FIFO, and writing 1 to bit 15 flushes the receive FIFO. The flush bit reads 1 in the cycle after the write and 0 after that. The count becomes 0, and pushes and pops in the flush cycle have no effect and raise no flag.
- R4: Address 1 reports the transmit count in bits 23:16 and the receive count in bits 7:0. Each count stays between 0 and 64, and a push and a pop in the same cycle are both applied.
- R5: A transmit data write when the transmit count is 64 is dropped and sets status bit 10. An engine receive push when the receive count is 64 is dropped and sets status bit 8.
- R6: A receive data read when the receive count is 0 returns 0 and sets status bit 9. An engine transmit pop when the transmit count is 0 sets status bit 11.
- R7: Status bit 4 is set when the transmit count is at or below the transmit trigger. Status bit 0 is set when the receive count is at or above the receive trigger.
- R8: Status bit 1 flags receive empty, bit 2 receive full, bit 5 transmit empty and bit 6 transmit full.
- R9: An engine transfer-done pulse sets status bit 12, and an engine chip-select-inactive pulse sets status bit 13.
- R10: A write to status (address 3) clears every bit written as 1. A level flag (bits 0,1,2,4,5,6) is clear for one cycle and is set again on the next edge if its condition holds. An event (bits 8 to 13) arriving in the same cycle as its clear is kept. Without a clear, no status bit falls.
- R11: Enable (address 2) stores only bits 0-2, 4-6 and 8-13. irq is high exactly when some status bit and the matching enable bit are both 1.
- R12: reg_rdata takes the addressed value on the edge where reg_rd is sampled high and holds otherwise. Unused addresses, and address 5, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| eng_tx_pop | input | 1 | Shift engine takes one transmit byte |
| eng_rx_push | input | 1 | Shift engine delivers one receive byte |
| eng_xfer_done | input | 1 | Transfer complete pulse |
| eng_cs_inactive | input | 1 | Chip select went inactive pulse |
| irq | output | 1 | Interrupt request |

## Verification
Counts, triggers, flush bits and event flags change on the first clock edge after the stimulus. Level flags follow the count one edge later, and irq follows the status register in the same cycle. Read data appears on the edge that samples reg_rd. The bench drives each stimulus at the falling edge and updates its own model of counts, triggers and flags in the same order of edges. It compares irq and any read data at the next falling edge, so every comparison sees the value due in that cycle. The directed reads of the flag after a clear check the one-cycle gap before a level flag is set again.

// File: rtl/spi_fifo_irq_pkg.sv
// Shared constants for the FIFO status and interrupt unit: register
// addresses, status bit positions and the masks that group the bits.
package spi_fifo_irq_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int FIELD_W = 8;
    localparam int STAT_W  = 14;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_LEVEL = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_IEN   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_IST   = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_TXD   = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_RXD   = 3'd5;

    localparam int ST_RX_REQ  = 0;
    localparam int ST_RX_EMP  = 1;
    localparam int ST_RX_FULL = 2;
    localparam int ST_TX_REQ  = 4;
    localparam int ST_TX_EMP  = 5;
    localparam int ST_TX_FULL = 6;
    localparam int ST_RX_OVF  = 8;
    localparam int ST_RX_UDR  = 9;
    localparam int ST_TX_OVF  = 10;
    localparam int ST_TX_UDR  = 11;
    localparam int ST_DONE    = 12;
    localparam int ST_CS_OFF  = 13;

    localparam logic [STAT_W-1:0] LEVEL_MASK = 14'h0077;
    localparam logic [STAT_W-1:0] EVENT_MASK = 14'h3F00;
    localparam logic [STAT_W-1:0] VALID_MASK = LEVEL_MASK | EVENT_MASK;
endpackage

// File: rtl/fifo_occupancy.sv
// Occupancy model of one byte FIFO. It holds only the count, not the data.
// Assumes push and pop are single-cycle strobes. A flush clears the count
// and suppresses every other effect of that cycle. A push when full and a
// pop when empty are dropped and reported as one-cycle event pulses.
module fifo_occupancy #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    output logic [CNT_W-1:0] cnt,
    output logic             full,
    output logic             empty,
    output logic             overrun,
    output logic             underrun
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    assign full     = (cnt_q == CNT_MAX);
    assign empty    = (cnt_q == '0);
    assign overrun  = push && full && !flush;
    assign underrun = pop && empty && !flush;
    assign cnt      = cnt_q;

    // Next count: accepted push adds one, accepted pop removes one.
    always_comb begin
        cnt_nxt = cnt_q;
        if (push && !full) cnt_nxt = cnt_nxt + CNT_W'(1);
        if (pop && !empty) cnt_nxt = cnt_nxt - CNT_W'(1);
    end

    // Count register with flush taking priority over traffic.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (flush) cnt_q <= '0;
        else            cnt_q <= cnt_nxt;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX); // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (cnt_q == CNT_MAX)); // R5
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> (cnt_q == '0)); // R6
    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/fifo_ctrl_regs.sv
// Control register: the two trigger levels and the flush bits.
// Assumes the caller decodes the write strobe. A flush bit stays high for
// exactly the one cycle after the write that sets it, so the bit clears itself.
module fifo_ctrl_regs #(
    parameter int FIELD_W = 8,
    parameter logic [FIELD_W-1:0] TX_TRIG_RST = 8'd48,
    parameter logic [FIELD_W-1:0] RX_TRIG_RST = 8'd16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [FIELD_W-1:0] tx_trig_wd,
    input  logic [FIELD_W-1:0] rx_trig_wd,
    input  logic               tx_flush_wd,
    input  logic               rx_flush_wd,
    output logic [FIELD_W-1:0] tx_trig,
    output logic [FIELD_W-1:0] rx_trig,
    output logic               tx_flush,
    output logic               rx_flush
);
    // Trigger levels load on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_trig <= TX_TRIG_RST;
            rx_trig <= RX_TRIG_RST;
        end else if (wr) begin
            tx_trig <= tx_trig_wd;
            rx_trig <= rx_trig_wd;
        end
    end

    // Flush requests last one cycle and then drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flush <= 1'b0;
            rx_flush <= 1'b0;
        end else begin
            tx_flush <= wr && tx_flush_wd;
            rx_flush <= wr && rx_flush_wd;
        end
    end

    AST_TX_FLUSH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush && !wr) |=> !tx_flush); // R3
    AST_RX_FLUSH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush && !wr) |=> !rx_flush); // R3
    AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(tx_trig) && $stable(rx_trig))); // R2
endmodule

// File: rtl/irq_status_bank.sv
// Sticky status bits, enable mask and interrupt output.
// Assumes set_vec carries level conditions at level positions and one-cycle
// pulses at event positions. A write-one clear beats a level set for one
// cycle, but an event set beats its clear so no event is lost.
module irq_status_bank #(
    parameter int STAT_W = 14,
    parameter logic [STAT_W-1:0] LEVEL_BITS = 14'h0077,
    parameter logic [STAT_W-1:0] EVENT_BITS = 14'h3F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_wd,
    input  logic              en_wr,
    input  logic [STAT_W-1:0] en_wd,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] enable,
    output logic              irq
);
    localparam logic [STAT_W-1:0] KEEP_BITS = LEVEL_BITS | EVENT_BITS;

    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] status_nxt;

    assign clr_vec = clr_wr ? clr_wd : '0;

    // Merge old flags, clears, level sets and event sets.
    always_comb begin
        status_nxt = (status & ~clr_vec)
                   | (set_vec & LEVEL_BITS & ~clr_vec)
                   | (set_vec & EVENT_BITS);
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= status_nxt;
    end

    // Enable register, implemented bit positions only.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable <= '0;
        else if (en_wr) enable <= en_wd & KEEP_BITS;
    end

    // Interrupt line from enabled flags.
    assign irq = |(status & enable);

    AST_LEVEL_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((status & $past(clr_wd & LEVEL_BITS)) == '0)); // R10
    AST_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (($past(status) & ~status) == '0)); // R10
    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & EVENT_BITS) != '0) |=>
        ((status & $past(set_vec & EVENT_BITS)) == $past(set_vec & EVENT_BITS))); // R9
endmodule

// File: rtl/spi_fifo_irq_unit.sv
// Top of the FIFO status and interrupt unit. It decodes the register port,
// feeds the two occupancy models, builds the status set vector and registers
// read data. Assumes at most one of reg_wr and reg_rd is high per cycle and
// that DEPTH fits in an 8-bit count field.
module spi_fifo_irq_unit
    import spi_fifo_irq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic              eng_xfer_done,
    input  logic              eng_cs_inactive,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [FIELD_W-1:0] TX_TRIG_RST = FIELD_W'(3 * DEPTH / 4);
    localparam logic [FIELD_W-1:0] RX_TRIG_RST = FIELD_W'(DEPTH / 4);

    logic ctrl_wr, ien_wr, ist_wr, txd_wr, rxd_rd;
    logic [FIELD_W-1:0] tx_trig, rx_trig;
    logic tx_flush, rx_flush;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic tx_full, tx_empty, tx_ovf, tx_udr;
    logic rx_full, rx_empty, rx_ovf, rx_udr;
    logic [FIELD_W-1:0] tx_cnt_f, rx_cnt_f;
    logic [STAT_W-1:0] set_vec, status, enable;
    logic [DATA_W-1:0] rd_mux;
    logic unused_wdata;

    assign unused_wdata = ^{reg_wdata[30:24], reg_wdata[14]};

    // Register strobe decode.
    always_comb begin
        ctrl_wr = reg_wr && (reg_addr == ADR_CTRL);
        ien_wr  = reg_wr && (reg_addr == ADR_IEN);
        ist_wr  = reg_wr && (reg_addr == ADR_IST);
        txd_wr  = reg_wr && (reg_addr == ADR_TXD);
        rxd_rd  = reg_rd && (reg_addr == ADR_RXD);
    end

    fifo_ctrl_regs #(
        .FIELD_W     (FIELD_W),
        .TX_TRIG_RST (TX_TRIG_RST),
        .RX_TRIG_RST (RX_TRIG_RST)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (ctrl_wr),
        .tx_trig_wd  (reg_wdata[23:16]),
        .rx_trig_wd  (reg_wdata[7:0]),
        .tx_flush_wd (reg_wdata[31]),
        .rx_flush_wd (reg_wdata[15]),
        .tx_trig     (tx_trig),
        .rx_trig     (rx_trig),
        .tx_flush    (tx_flush),
        .rx_flush    (rx_flush)
    );

    fifo_occupancy #(.DEPTH(DEPTH)) u_tx_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (tx_flush),
        .push     (txd_wr),
        .pop      (eng_tx_pop),
        .cnt      (tx_cnt),
        .full     (tx_full),
        .empty    (tx_empty),
        .overrun  (tx_ovf),
        .underrun (tx_udr)
    );

    fifo_occupancy #(.DEPTH(DEPTH)) u_rx_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (rx_flush),
        .push     (eng_rx_push),
        .pop      (rxd_rd),
        .cnt      (rx_cnt),
        .full     (rx_full),
        .empty    (rx_empty),
        .overrun  (rx_ovf),
        .underrun (rx_udr)
    );

    assign tx_cnt_f = FIELD_W'(tx_cnt);
    assign rx_cnt_f = FIELD_W'(rx_cnt);

    // Status set sources: level conditions from current counts, event pulses.
    always_comb begin
        set_vec             = '0;
        set_vec[ST_RX_REQ]  = (rx_cnt_f >= rx_trig);
        set_vec[ST_RX_EMP]  = rx_empty;
        set_vec[ST_RX_FULL] = rx_full;
        set_vec[ST_TX_REQ]  = (tx_cnt_f <= tx_trig);
        set_vec[ST_TX_EMP]  = tx_empty;
        set_vec[ST_TX_FULL] = tx_full;
        set_vec[ST_RX_OVF]  = rx_ovf;
        set_vec[ST_RX_UDR]  = rx_udr;
        set_vec[ST_TX_OVF]  = tx_ovf;
        set_vec[ST_TX_UDR]  = tx_udr;
        set_vec[ST_DONE]    = eng_xfer_done;
        set_vec[ST_CS_OFF]  = eng_cs_inactive;
    end

    irq_status_bank #(
        .STAT_W     (STAT_W),
        .LEVEL_BITS (LEVEL_MASK),
        .EVENT_BITS (EVENT_MASK)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_wr  (ist_wr),
        .clr_wd  (reg_wdata[STAT_W-1:0]),
        .en_wr   (ien_wr),
        .en_wd   (reg_wdata[STAT_W-1:0]),
        .status  (status),
        .enable  (enable),
        .irq     (irq)
    );

    // Read-back selection; data windows read as zero.
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            ADR_CTRL:  rd_mux = {tx_flush, 7'd0, tx_trig, rx_flush, 7'd0, rx_trig};
            ADR_LEVEL: rd_mux = {8'd0, tx_cnt_f, 8'd0, rx_cnt_f};
            ADR_IEN:   rd_mux = {{(DATA_W-STAT_W){1'b0}}, enable};
            ADR_IST:   rd_mux = {{(DATA_W-STAT_W){1'b0}}, status};
            default:   rd_mux = '0;
        endcase
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R12
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq); // R11
endmodule

// File: tb/spi_fifo_irq_unit_bench.sv
module spi_fifo_irq_unit_bench;
    localparam int DEPTH = 64;
    localparam logic [13:0] LVL = 14'h0077;
    localparam logic [13:0] VLD = 14'h3F77;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b_wr = 0, b_rd = 0, b_pop = 0, b_push = 0, b_done = 0, b_csi = 0;
    logic [2:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // Bench model state
    int m_tcnt, m_rcnt;
    logic [7:0] m_ttrig, m_rtrig;
    logic m_tfl, m_rfl;
    logic [13:0] m_en, m_st;

    always #4 clk = ~clk; // 125 MHz

    spi_fifo_irq_unit u_spi_fifo_irq_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(b_wr), .reg_rd(b_rd), .reg_addr(b_addr),
        .reg_wdata(b_wdata), .reg_rdata(reg_rdata), .eng_tx_pop(b_pop),
        .eng_rx_push(b_push), .eng_xfer_done(b_done), .eng_cs_inactive(b_csi),
        .irq(irq)
    );

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return {m_tfl, 7'd0, m_ttrig, m_rfl, 7'd0, m_rtrig};
            3'd1: return {8'd0, 8'(m_tcnt), 8'd0, 8'(m_rcnt)};
            3'd2: return {18'd0, m_en};
            3'd3: return {18'd0, m_st};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tcnt = 0; m_rcnt = 0; m_ttrig = 8'd48; m_rtrig = 8'd16;
        m_tfl = 0; m_rfl = 0; m_en = '0; m_st = '0;
    endtask

    // One clock: advance the model, then compare irq and any read data.
    task automatic step(input string tag);
        logic [31:0] er;
        logic [13:0] lev, ev, clr;
        logic tpush, rpop;
        er = exp_read(b_addr);
        lev = '0; ev = '0;
        lev[0] = (m_rcnt >= int'(m_rtrig)); lev[1] = (m_rcnt == 0); lev[2] = (m_rcnt == DEPTH);
        lev[4] = (m_tcnt <= int'(m_ttrig)); lev[5] = (m_tcnt == 0); lev[6] = (m_tcnt == DEPTH);
        tpush = b_wr && (b_addr == 3'd4);
        rpop  = b_rd && (b_addr == 3'd5);
        if (m_tfl) m_tcnt = 0;
        else begin
            ev[10] = tpush && (m_tcnt == DEPTH);
            ev[11] = b_pop && (m_tcnt == 0);
            m_tcnt = m_tcnt + ((tpush && m_tcnt < DEPTH) ? 1 : 0) - ((b_pop && m_tcnt > 0) ? 1 : 0);
        end
        if (m_rfl) m_rcnt = 0;
        else begin
            ev[8] = b_push && (m_rcnt == DEPTH);
            ev[9] = rpop && (m_rcnt == 0);
            m_rcnt = m_rcnt + ((b_push && m_rcnt < DEPTH) ? 1 : 0) - ((rpop && m_rcnt > 0) ? 1 : 0);
        end
        ev[12] = b_done; ev[13] = b_csi;
        clr = (b_wr && b_addr == 3'd3) ? b_wdata[13:0] : '0;
        m_st = (m_st & ~clr) | (lev & LVL & ~clr) | ev;
        if (b_wr && b_addr == 3'd0) begin
            m_ttrig = b_wdata[23:16]; m_rtrig = b_wdata[7:0];
            m_tfl = b_wdata[31]; m_rfl = b_wdata[15];
        end else begin
            m_tfl = 0; m_rfl = 0;
        end
        if (b_wr && b_addr == 3'd2) m_en = b_wdata[13:0] & VLD;
        @(posedge clk);
        @(negedge clk);
        chk("R11 irq", {31'd0, irq}, {31'd0, |(m_st & m_en)});
        if (b_rd) chk(tag, reg_rdata, er);
        b_wr = 0; b_rd = 0; b_pop = 0; b_push = 0; b_done = 0; b_csi = 0;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [31:0] d, input string tag);
        b_wr = 1; b_addr = a; b_wdata = d;
        step(tag);
    endtask

    task automatic do_read(input logic [2:0] a, input string tag);
        b_rd = 1; b_addr = a;
        step(tag);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd2024);
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        do_read(3'd0, "R1 control reset");
        chk("R1 control value", reg_rdata, 32'h0030_0010);
        do_read(3'd2, "R1 enable reset");
        chk("R1 enable value", reg_rdata, 32'd0);
        do_read(3'd1, "R1 counts reset");
        chk("R1 count value", reg_rdata, 32'd0);

        do_write(3'd2, 32'hFFFF_FFFF, "R11");
        do_read(3'd2, "R11 enable mask");
        chk("R11 enable mask value", reg_rdata, 32'h0000_3F77);

        for (int i = 0; i < DEPTH + 2; i++) do_write(3'd4, 32'hA5, "R4");
        do_read(3'd1, "R4 tx count");
        chk("R4 tx full count", reg_rdata, 32'h0040_0000);
        do_read(3'd3, "R5 status");
        chk("R5 tx overrun bit10", {31'd0, reg_rdata[10]}, 32'd1);
        chk("R8 tx full bit6", {31'd0, reg_rdata[6]}, 32'd1);

        do_read(3'd5, "R6 empty rx read");
        chk("R6 empty read data", reg_rdata, 32'd0);
        do_read(3'd3, "R6 status");
        chk("R6 rx underrun bit9", {31'd0, reg_rdata[9]}, 32'd1);

        do_write(3'd3, 32'h3F77, "R10");
        do_read(3'd3, "R10 after clear");
        chk("R10 full bit cleared", {31'd0, reg_rdata[6]}, 32'd0);
        chk("R10 overrun cleared", {31'd0, reg_rdata[10]}, 32'd0);
        do_read(3'd3, "R10 re-set");
        chk("R10 full bit back", {31'd0, reg_rdata[6]}, 32'd1);

        do_write(3'd0, 32'h8000_0002, "R3");
        do_read(3'd0, "R3 flush bit visible");
        chk("R3 flush bit high", {31'd0, reg_rdata[31]}, 32'd1);
        do_read(3'd1, "R3 count flushed");
        chk("R3 tx count zero", reg_rdata, 32'd0);
        do_read(3'd0, "R2 control readback");
        chk("R2 trig fields, R3 bit self-cleared", reg_rdata, 32'h0000_0002);

        do_write(3'd3, 32'h3F77, "R10");
        b_push = 1; step("R7");
        b_push = 1; step("R7");
        step("R7");
        do_read(3'd3, "R7 status");
        chk("R7 rx ready bit0", {31'd0, reg_rdata[0]}, 32'd1);
        chk("R7 tx request bit4", {31'd0, reg_rdata[4]}, 32'd1);

        b_done = 1; b_csi = 1; step("R9");
        do_read(3'd3, "R9 status");
        chk("R9 done bit12", {31'd0, reg_rdata[12]}, 32'd1);
        chk("R9 cs bit13", {31'd0, reg_rdata[13]}, 32'd1);

        do_write(3'd2, 32'h0000_1000, "R11");
        do_write(3'd3, 32'h3F77, "R11");
        chk("R11 irq low after clear", {31'd0, irq}, 32'd0);
        b_done = 1; step("R11");
        chk("R11 irq high on done", {31'd0, irq}, 32'd1);

        b_done = 1; b_wr = 1; b_addr = 3'd3; b_wdata = 32'h1000; step("R10");
        chk("R10 event kept over clear", {31'd0, irq}, 32'd1);

        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom % 100);
            b_pop  = ($urandom % 100) < 30;
            b_push = ($urandom % 100) < 35;
            b_done = ($urandom % 100) < 3;
            b_csi  = ($urandom % 100) < 3;
            if (r < 30) do_write(3'd4, $urandom, "R4 random");
            else if (r < 45) do_read(3'd5, "R6 random rx read");
            else if (r < 52) do_write(3'd0, {($urandom % 8) == 0, 7'd0, 8'($urandom % 70),
                                            ($urandom % 8) == 0, 7'd0, 8'($urandom % 70)}, "R2 random");
            else if (r < 58) do_write(3'd2, $urandom, "R11 random");
            else if (r < 68) do_write(3'd3, $urandom, "R10 random");
            else if (r < 85) begin
                logic [2:0] a;
                a = 3'($urandom % 6);
                case (a)
                    3'd0: do_read(a, "R2 R3 random ctrl read");
                    3'd1: do_read(a, "R4 random count read");
                    3'd2: do_read(a, "R11 random enable read");
                    3'd3: do_read(a, "R10 R7 R8 random status read");
                    default: do_read(a, "R12 random data read");
                endcase
            end else step("R12 idle");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule